// File: doc/BRIEF.md
# SPI Master Controller with Byte FIFOs

This block is a single-chip-select SPI master that software drives through a small register bus. Bytes written to the data register queue in a transmit FIFO and shift out on the serial line while chip select is active. A receive byte counter lets the controller clock in data on its own: it sends all-ones frames and stores each incoming byte in a receive FIFO. Reading the data register pops that FIFO.

Clock polarity, clock phase, bit order, loopback and a clock divider are set in a configuration register. Status flags and interrupt enables use the same bit positions, and the level interrupt is their masked OR. A sticky abort flag records a write that arrived while the transmit FIFO was full. While the flag is set, further data writes are refused.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0 and irq_o is 0. The control register (0x08) reads 0xA0, the interrupt register (0x20) reads 0x00 and the count register (0x18) reads 0x00.
- R2: Writing bit0=1 to the control register (0x08) asserts cs_no low. Bytes written to the data register (0x00) are then sent on mosi_o in write order, 8 bits per byte. Bytes that are only transmitted are not stored in the receive FIFO.
- R3: Configuration register (0x10) bit5 sets the idle level of sclk_o and bit4 sets the phase. With bit4=0, data is sampled on the leading edge. With bit4=1, data is sampled on the trailing edge. All four modes transfer correctly.
- R4: Configuration bit3=1 sends and receives least significant bit first. With bit3=0 the most significant bit goes first.
- R5: Configuration bits[2:0] (value d) set the sclk_o period to 2*(floor(d/2)+1) system clocks. The value 7 gives 8 clocks.
- R6: Writing N>0 to the count register with chip select active makes the controller send N frames of 0xFF. Each byte received on miso_i is stored. The count drops by one for each stored byte and ends at 0. Reads of the data register return the bytes in arrival order.
- R7: When the receive FIFO (32 bytes) is full, shifting pauses and the count register holds the number of bytes still to come. Reading one byte lets exactly one more byte arrive.
- R8: Status bits in the control register are bit7 transmit empty, bit6 transmit full, bit5 receive empty and bit4 receive full. irq_o is the OR of each status bit ANDed with the matching enable in bits 7..4 of the interrupt register.
- R9: A data write while the transmit FIFO is full sets interrupt register bit2. While that bit is set, data writes are dropped. Writing 1 to bit2 clears it.
- R10: Configuration bit7=1 empties both FIFOs and keeps them empty while it stays set.
- R11: Writing bit1=1 to the control register releases chip select only after the transmit FIFO has drained and the current byte has finished. Interrupt register bit0 reads 1 while chip select is active.
- R12: Configuration bit6=1 feeds mosi_o back to the receive path, and miso_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte offset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops receive FIFO at 0x00) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the receive pause: the receive FIFO must be full while the byte counter is still nonzero. The bench gets there by loading a count larger than the FIFO depth and letting the controller run without reading. It then checks the remaining count and the full flag. Next it pops a single byte and confirms that exactly one more frame arrives before the controller stops again. A bench-side slave model follows sclk_o in each phase mode, so every mode is checked against an independently captured bit stream.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned ADDR_W  = 6;

  localparam logic [ADDR_W-1:0] OFF_DATA  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CFG   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_RXCNT = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 6'h20;

  typedef struct packed {
    logic tx_empty;
    logic tx_full;
    logic rx_empty;
    logic rx_full;
  } stat_t;
endpackage

// File: rtl/spi_sfifo.sv
module spi_sfifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;

  logic do_push, do_pop;
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign data_o  = mem[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r10_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned W     = 8,
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [W-1:0]     tx_byte_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             lsb_first_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [W-1:0]     rx_byte_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  localparam int unsigned CW = $clog2(2*W);

  logic             busy_q, done_q, sclk_q, cpha_q, lsb_q;
  logic [DIV_W-1:0] half_q, tick_q;
  logic [CW-1:0]    edge_q;
  logic [W-1:0]     tx_sh_q, rx_sh_q, tx_rev, rx_rev;
  logic             sample_now, shift_now, tick;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign tx_rev[g] = tx_byte_i[W-1-g];
    assign rx_rev[g] = rx_sh_q[W-1-g];
  end

  assign tick       = (tick_q == half_q);
  assign sample_now = (edge_q[0] == cpha_q);
  assign shift_now  = (edge_q[0] != cpha_q) && (edge_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b0;
      cpha_q  <= 1'b0;
      lsb_q   <= 1'b0;
      half_q  <= '0;
      tick_q  <= '0;
      edge_q  <= '0;
      tx_sh_q <= '1;
      rx_sh_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        tick_q  <= '0;
        edge_q  <= '0;
        sclk_q  <= cpol_i;
        cpha_q  <= cpha_i;
        lsb_q   <= lsb_first_i;
        half_q  <= div_i >> 1;
        tx_sh_q <= lsb_first_i ? tx_rev : tx_byte_i;
      end else if (busy_q) begin
        if (tick) begin
          tick_q <= '0;
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
          if (sample_now) rx_sh_q <= {rx_sh_q[W-2:0], miso_i};
          if (shift_now)  tx_sh_q <= {tx_sh_q[W-2:0], 1'b1};
          if (edge_q == CW'(2*W-1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_byte_o = lsb_q ? rx_rev : rx_sh_q;
  assign sclk_o    = busy_q ? sclk_q : cpol_i;
  assign mosi_o    = tx_sh_q[W-1];

  a_r2_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r5_tick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> tick_q <= half_q);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_fifo_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned DIV_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              irq_o
);
  localparam int unsigned W = FRAME_W;

  logic             cs_q, rel_q, abort_q, cur_rx_q;
  logic             clr_q, loop_q, cpol_q, cpha_q, lsb_q;
  logic [DIV_W-1:0] div_q;
  logic [W-1:0]     rxcnt_q;
  logic [3:0]       ien_q;

  logic wr_data, wr_ctrl, wr_cfg, wr_cnt, wr_ien, rd_data;
  assign wr_data = wr_i && (addr_i == OFF_DATA);
  assign wr_ctrl = wr_i && (addr_i == OFF_CTRL);
  assign wr_cfg  = wr_i && (addr_i == OFF_CFG);
  assign wr_cnt  = wr_i && (addr_i == OFF_RXCNT);
  assign wr_ien  = wr_i && (addr_i == OFF_IEN);
  assign rd_data = rd_i && (addr_i == OFF_DATA);

  stat_t        st;
  logic [W-1:0] tx_head, rx_head, rx_byte, start_byte;
  logic         tx_push, tx_pop, rx_push, rx_pop, abort_set;
  logic         busy, done, start, tx_go, rx_go, idle_ok, release_ok, miso_int;

  assign abort_set = wr_data && !abort_q && st.tx_full;
  assign tx_push   = wr_data && !abort_q && !st.tx_full && !clr_q;
  assign rx_pop    = rd_data && !st.rx_empty;

  assign idle_ok    = cs_q && !busy && !done;
  assign tx_go      = idle_ok && !st.tx_empty;
  assign rx_go      = idle_ok && st.tx_empty && (rxcnt_q != '0) && !st.rx_full && !clr_q;
  assign start      = tx_go || rx_go;
  assign tx_pop     = tx_go;
  assign start_byte = tx_go ? tx_head : '1;
  assign rx_push    = done && cur_rx_q && !clr_q;
  assign release_ok = rel_q && st.tx_empty && !busy && !start;
  assign miso_int   = loop_q ? mosi_o : miso_i;

  spi_sfifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(clr_q),
    .push_i(tx_push), .data_i(wdata_i), .pop_i(tx_pop),
    .data_o(tx_head), .empty_o(st.tx_empty), .full_o(st.tx_full)
  );

  spi_sfifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(clr_q),
    .push_i(rx_push), .data_i(rx_byte), .pop_i(rx_pop),
    .data_o(rx_head), .empty_o(st.rx_empty), .full_o(st.rx_full)
  );

  spi_shift #(.W(W), .DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni,
    .start_i(start), .tx_byte_i(start_byte),
    .cpol_i(cpol_q), .cpha_i(cpha_q), .lsb_first_i(lsb_q), .div_i(div_q),
    .miso_i(miso_int), .busy_o(busy), .done_o(done), .rx_byte_o(rx_byte),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b0;
      rel_q    <= 1'b0;
      abort_q  <= 1'b0;
      cur_rx_q <= 1'b0;
      clr_q    <= 1'b0;
      loop_q   <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      lsb_q    <= 1'b0;
      div_q    <= '0;
      rxcnt_q  <= '0;
      ien_q    <= '0;
    end else begin
      if (start) cur_rx_q <= rx_go;
      if (release_ok) begin
        cs_q  <= 1'b0;
        rel_q <= 1'b0;
      end
      if (wr_ctrl && wdata_i[0]) cs_q  <= 1'b1;
      if (wr_ctrl && wdata_i[1]) rel_q <= 1'b1;
      if (abort_set) abort_q <= 1'b1;
      else if (wr_ien && wdata_i[2]) abort_q <= 1'b0;
      if (wr_ien) ien_q <= wdata_i[7:4];
      if (wr_cfg) begin
        clr_q  <= wdata_i[7];
        loop_q <= wdata_i[6];
        cpol_q <= wdata_i[5];
        cpha_q <= wdata_i[4];
        lsb_q  <= wdata_i[3];
        div_q  <= wdata_i[DIV_W-1:0];
      end
      if (wr_cnt) rxcnt_q <= wdata_i;
      else if (done && cur_rx_q) rxcnt_q <= rxcnt_q - 1'b1;
    end
  end

  always_comb begin
    case (addr_i)
      OFF_DATA:  rdata_o = rx_head;
      OFF_CTRL:  rdata_o = {st, 2'b00, rel_q, cs_q};
      OFF_CFG:   rdata_o = {clr_q, loop_q, cpol_q, cpha_q, lsb_q, div_q};
      OFF_RXCNT: rdata_o = rxcnt_q;
      OFF_IEN:   rdata_o = {ien_q, 1'b0, abort_q, 1'b0, cs_q};
      default:   rdata_o = '0;
    endcase
  end

  assign cs_no = ~cs_q;
  assign irq_o = |(st & ien_q);

  a_r11_cs_covers_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_q |-> !busy);
  a_r11_release_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |-> $past(st.tx_empty) && !busy);
  a_r6_count_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt |=> rxcnt_q <= $past(rxcnt_q));
  a_r9_abort_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q && !(wr_ien && wdata_i[2]) |=> abort_q);
endmodule

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
  import spi_fifo_pkg::*;

  logic       clk = 0, rst_n = 0;
  logic [5:0] addr = '0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = '0, rdata;
  logic       sclk_o, mosi_o, cs_no, irq_o;
  logic       miso_i = 0;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  // slave model state
  bit        cpol_tb = 0, cpha_tb = 0, lead;
  logic [7:0]  pat = 8'h00;
  logic [15:0] cap = '0;
  int ncap = 0, bidx = 0;

  // {cfg, tx byte, slave pattern, expected wire byte, expected rx byte}
  localparam logic [39:0] VEC [6] = '{
    40'h00_A5_3C_A5_3C,
    40'h10_96_C3_96_C3,
    40'h20_5A_0F_5A_0F,
    40'h30_12_E1_12_E1,
    40'h08_13_2C_C8_34,
    40'h48_13_00_C8_FF
  };

  spi_byte_master dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .cs_no(cs_no), .irq_o(irq_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(sclk_o) begin
    if (cs_no === 1'b0) begin
      lead = (sclk_o != cpol_tb);
      if (lead != cpha_tb) begin
        cap  = {cap[14:0], mosi_o};
        ncap = ncap + 1;
        bidx = bidx + 1;
        miso_i = pat[7 - (bidx % 8)];
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic set_slave(input logic [7:0] cfg, input logic [7:0] p);
    cpol_tb = cfg[5]; cpha_tb = cfg[4];
    pat = p; bidx = 0; ncap = 0; cap = '0; miso_i = p[7];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int t0, t1;
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    chk("R1 cs_no", cs_no, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 irq", irq_o, 0);
    rreg(OFF_CTRL, d);  chk("R1 ctrl", d, 8'hA0);
    rreg(OFF_IEN, d);   chk("R1 ien", d, 8'h00);
    rreg(OFF_RXCNT, d); chk("R1 cnt", d, 8'h00);

    // R2 R3 R4 R6 R12 vector walk
    foreach (VEC[i]) begin
      set_slave(VEC[i][39:32], VEC[i][23:16]);
      wreg(OFF_CFG, VEC[i][39:32]);
      wreg(OFF_DATA, VEC[i][31:24]);
      wreg(OFF_CTRL, 8'h01);
      idle(40);
      chk($sformatf("R2 R3 R4 vec%0d cs", i), cs_no, 0);
      chk($sformatf("R2 R3 R4 vec%0d bits", i), ncap, 8);
      chk($sformatf("R2 R3 R4 vec%0d wire", i), cap[7:0], VEC[i][15:8]);
      rreg(OFF_CTRL, d);
      chk($sformatf("R2 vec%0d rx not stored", i), d[5], 1);
      wreg(OFF_RXCNT, 8'h01);
      idle(40);
      rreg(OFF_DATA, d);
      chk($sformatf("R6 R12 vec%0d rx", i), d, VEC[i][7:0]);
      rreg(OFF_RXCNT, d);
      chk($sformatf("R6 vec%0d cnt", i), d, 0);
      chk($sformatf("R6 vec%0d dummy", i), cap[7:0], 8'hFF);
      wreg(OFF_CTRL, 8'h02);
      idle(5);
      chk($sformatf("R11 vec%0d released", i), cs_no, 1);
    end

    // R5 divider 7 -> period 8
    set_slave(8'h07, 8'h00);
    wreg(OFF_CFG, 8'h07);
    wreg(OFF_DATA, 8'h55);
    wreg(OFF_CTRL, 8'h01);
    @(posedge sclk_o); t0 = cyc;
    @(posedge sclk_o); t1 = cyc;
    chk("R5 period", t1 - t0, 8);
    idle(100);
    chk("R5 wire", cap[7:0], 8'h55);
    wreg(OFF_CTRL, 8'h02); idle(5);

    // R11 release waits for drain
    set_slave(8'h00, 8'h00);
    wreg(OFF_CFG, 8'h00);
    wreg(OFF_DATA, 8'hC3);
    wreg(OFF_DATA, 8'h3C);
    wreg(OFF_CTRL, 8'h01);
    wreg(OFF_CTRL, 8'h02);
    chk("R11 held during shift", cs_no, 0);
    rreg(OFF_IEN, d); chk("R11 cs bit active", d, 8'h01);
    idle(60);
    chk("R11 released", cs_no, 1);
    rreg(OFF_IEN, d); chk("R11 cs bit idle", d, 8'h00);
    chk("R2 two bytes", cap, 16'hC33C);

    // R8 interrupt masking
    wreg(OFF_IEN, 8'h80); idle(1); chk("R8 tx_empty irq", irq_o, 1);
    wreg(OFF_IEN, 8'h10); idle(1); chk("R8 rx_full masked", irq_o, 0);
    wreg(OFF_IEN, 8'h20); idle(1); chk("R8 rx_empty irq", irq_o, 1);
    wreg(OFF_IEN, 8'h00); idle(1); chk("R8 none", irq_o, 0);

    // R7 receive pause on full FIFO
    set_slave(8'h00, 8'hA5);
    wreg(OFF_RXCNT, 8'd40);
    wreg(OFF_CTRL, 8'h01);
    idle(800);
    rreg(OFF_RXCNT, d); chk("R7 count held", d, 8);
    rreg(OFF_CTRL, d);  chk("R7 R8 full status", d, 8'h91);
    wreg(OFF_IEN, 8'h10); idle(1); chk("R8 rx_full irq", irq_o, 1);
    rreg(OFF_DATA, d);  chk("R6 R7 first byte", d, 8'hA5);
    idle(60);
    rreg(OFF_RXCNT, d); chk("R7 one more", d, 7);
    rreg(OFF_CTRL, d);  chk("R7 full again", d, 8'h91);
    wreg(OFF_RXCNT, 8'h00);
    wreg(OFF_CFG, 8'h80);
    rreg(OFF_CTRL, d);  chk("R10 both emptied", d, 8'hA1);
    wreg(OFF_CFG, 8'h00);
    wreg(OFF_CTRL, 8'h02);
    wreg(OFF_IEN, 8'h00);
    idle(5);

    // R9 R10 abort and clear
    for (int k = 0; k < 32; k++) wreg(OFF_DATA, 8'(k));
    rreg(OFF_CTRL, d); chk("R9 tx full", d, 8'h60);
    wreg(OFF_DATA, 8'hEE);
    rreg(OFF_IEN, d);  chk("R9 abort set", d, 8'h04);
    wreg(OFF_CFG, 8'h80);
    rreg(OFF_CTRL, d); chk("R10 cleared", d, 8'hA0);
    wreg(OFF_DATA, 8'h11);
    rreg(OFF_CTRL, d); chk("R10 held empty", d, 8'hA0);
    wreg(OFF_CFG, 8'h00);
    wreg(OFF_DATA, 8'h22);
    rreg(OFF_CTRL, d); chk("R9 write dropped", d, 8'hA0);
    wreg(OFF_IEN, 8'h04);
    rreg(OFF_IEN, d);  chk("R9 abort cleared", d, 8'h00);
    wreg(OFF_DATA, 8'h33);
    rreg(OFF_CTRL, d); chk("R9 write accepted", d, 8'h20);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule